// File: doc/BRIEF.md
# Dual-Mode RGMII/RMII MAC-Side Pin Adapter

This block sits between a byte-wide MAC stream and the pins of an Ethernet PHY. The same 4-bit data group and the single control pin in each direction carry one of two protocols. RGMII uses a 4-bit double-data-rate bus whose clock scales with the link speed. RMII uses bits [1:0] only, at single data rate, on a 50 MHz clock that is shared by both directions. Two static inputs select the protocol and the link speed. They may only change while the block is in reset.

On transmit, the MAC presents a byte with valid and error flags. The block accepts the byte in the cycle in which `txReady` is high. It then drives the byte onto the pins as one DDR byte, two nibbles or four dibits. On receive, the block captures the pins on both clock edges and reassembles the pieces into bytes. It presents each byte for exactly one clock, together with an error flag. The double-edge launch and capture are modelled with paired rise and fall registers. The transmit pins select between these registers according to the level of the transmit clock.

Top module: `rgmiiRmiiAdapter`

## Requirements
- R1: While `rstN` is low, `phyTxCtl` and `phyTxd` are 0 and `rxValid` is 0.
- R2: With `modeRmii`=0 and `speedSel`=2'b10 (1 Gbps), an accepted byte appears in the clock after it is taken. Its bits [3:0] are on `phyTxd` during the high phase and bits [7:4] during the low phase. `phyTxCtl` is high in the high phase and equals valid AND NOT error in the low phase. `txReady` is high every clock.
- R3: With `modeRmii`=0 and `speedSel` 2'b00 or 2'b01, each byte takes two clocks, bits [3:0] first, and each nibble is held through both phases. `txReady` stays low during the second clock.
- R4: With `modeRmii`=1, each byte leaves as four dibits on `phyTxd[1:0]`, bits [1:0] first. `phyTxd[3:2]` is 0. `phyTxCtl` is high in both phases, and `txError` has no effect on it.
- R5: With `modeRmii`=1 and `speedSel`=2'b00, every dibit is held for 10 consecutive clocks. `txReady` is high for one clock in 40 while bytes stream.
- R6: When no valid byte is taken, `phyTxCtl` and `phyTxd` are 0 in both phases, whatever `txData` and `txError` hold.
- R7: With RGMII at 1 Gbps, the received byte is {falling-edge nibble, rising-edge nibble}. Valid is the rising-edge control value. `rxError` is the XOR of the rising-edge and falling-edge control values.
- R8: With RGMII at 10 or 100 Mbps, two rising-edge nibbles with control high form one byte, the first nibble in bits [3:0]. `rxError` is set if either nibble carried an error.
- R9: With RMII, four dibits on `phyRxd[1:0]`, the first in bits [1:0], form one byte. `phyRxd[3:2]` is ignored and `rxError` stays 0. At `speedSel`=2'b00 one sample is taken per 10 clocks.
- R10: If the receive control drops before a byte is complete, the partial byte is discarded, and assembly restarts at the next valid sample.
- R11: `rxValid` pulses for exactly one clock per received byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| txClk | input | 1 | Transmit interface clock |
| rxClk | input | 1 | Receive interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeRmii | input | 1 | 1 selects RMII, 0 selects RGMII |
| speedSel | input | 2 | 2'b00 10 Mbps, 2'b01 100 Mbps, 2'b10 1 Gbps |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Transmit byte is valid |
| txError | input | 1 | Transmit byte carries an error |
| txReady | output | 1 | Byte is taken at the next txClk rising edge |
| phyTxd | output | 4 | Transmit data pins |
| phyTxCtl | output | 1 | Transmit control pin |
| phyRxd | input | 4 | Receive data pins |
| phyRxCtl | input | 1 | Receive control pin |
| rxData | output | 8 | Reassembled receive byte |
| rxValid | output | 1 | One-clock strobe for rxData |
| rxError | output | 1 | Error flag for the byte in rxData |

## Verification
The embedded properties assume that `modeRmii` and `speedSel` change only under reset. Without that, beat indices and held pin values could legitimately jump between lane shapes. They also assume that every receive pin value is stable around the edge that samples it. The stimulus therefore asserts reset at every mode change and moves each receive pin a quarter period before the edge that captures it. It also keeps every RMII dibit for a full 10-clock window at 10 Mbps, so that exactly one sample lands in each window whatever the divider phase.

// File: rtl/rgmiiRmiiPkg.sv
package rgmiiRmiiPkg;

  localparam int NIB_W   = 4;
  localparam int DIBIT_W = 2;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    SPD_10M  = 2'b00,
    SPD_100M = 2'b01,
    SPD_1G   = 2'b10,
    SPD_RSVD = 2'b11
  } linkSpeed_e;

  // Shape of one byte on the pins
  typedef enum logic [1:0] {
    LANE_DDR_BYTE,   // whole byte per clock, nibble per edge
    LANE_DDR_NIB,    // one nibble per clock, repeated on both edges
    LANE_SDR_DIBIT   // one dibit per beat, rising edge only
  } laneMode_e;

  // Strobes from a beat controller to a datapath
  typedef struct packed {
    logic beat;   // this edge advances the lane
    logic first;  // beat carries piece 0 of a byte
    logic last;   // beat carries the final piece of a byte
  } beatStrobe_t;

  function automatic laneMode_e laneOf(input logic rmii, input logic [1:0] spd);
    if (rmii)
      return LANE_SDR_DIBIT;
    else if (spd == SPD_1G)
      return LANE_DDR_BYTE;
    else
      return LANE_DDR_NIB;
  endfunction

endpackage

// File: rtl/rgmiiRmiiBeatCtrl.sv
module rgmiiRmiiBeatCtrl
  import rgmiiRmiiPkg::*;
#(
  parameter int SLOW_DIV  = 10,
  parameter int MAX_BEATS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeRmii,
  input  logic [1:0]  speedSel,
  input  logic        advance,
  output beatStrobe_t strobe
);

  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int IDX_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);
  localparam logic [IDX_W-1:0] SDR_LAST = IDX_W'(MAX_BEATS - 1);
  localparam logic [IDX_W-1:0] NIB_LAST = IDX_W'(1);

  laneMode_e        lane;
  logic             slowRate;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic             beat;

  assign lane     = laneOf(modeRmii, speedSel);
  assign slowRate = modeRmii && (speedSel == SPD_10M);

  always_comb begin
    case (lane)
      LANE_DDR_BYTE: lastIdx = '0;
      LANE_DDR_NIB:  lastIdx = NIB_LAST;
      default:       lastIdx = SDR_LAST;
    endcase
  end

  // Divider that spaces beats at the slow RMII rate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (slowRate) begin
      divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;
    end else begin
      divCnt <= '0;
    end
  end

  assign beat = slowRate ? (divCnt == '0) : 1'b1;

  // Piece index inside the current byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0;
    end else if (beat) begin
      if (advance && (idx != lastIdx))
        idx <= idx + 1'b1;
      else
        idx <= '0;
    end
  end

  assign strobe.beat  = beat;
  assign strobe.first = (idx == '0);
  assign strobe.last  = (idx == lastIdx);

  AST_BEAT_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN) idx <= lastIdx); // R3
  AST_SLOW_BEAT_SPACING: assert property (@(posedge clk) disable iff (!rstN) (slowRate && beat) |=> !beat); // R5

endmodule

// File: rtl/rgmiiRmiiTxPath.sv
module rgmiiRmiiTxPath
  import rgmiiRmiiPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeRmii,
  input  logic [1:0]        speedSel,
  input  beatStrobe_t       strobe,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  input  logic              txError,
  output logic [NIB_W-1:0]  riseD,
  output logic [NIB_W-1:0]  fallD,
  output logic              riseC,
  output logic              fallC
);

  laneMode_e         lane;
  logic              slowRate;
  logic [BYTE_W-1:0] holdByte;
  logic              holdValid;
  logic              holdErr;
  logic [BYTE_W-1:0] curByte;
  logic              curValid;
  logic              curErr;
  logic [BYTE_W-1:0] shifted;
  logic [NIB_W-1:0]  nextRise;
  logic [NIB_W-1:0]  nextFall;
  logic              nextFallC;

  assign lane     = laneOf(modeRmii, speedSel);
  assign slowRate = modeRmii && (speedSel == SPD_10M);

  // Piece 0 comes straight from the MAC, later pieces from the shifter
  assign curByte  = strobe.first ? txData : holdByte;
  assign curValid = strobe.first ? txValid : holdValid;
  assign curErr   = strobe.first ? (txError & txValid) : holdErr;

  always_comb begin
    nextRise = '0;
    nextFall = '0;
    shifted  = '0;
    case (lane)
      LANE_DDR_BYTE: begin
        nextRise = curByte[NIB_W-1:0];
        nextFall = curByte[BYTE_W-1:NIB_W];
      end
      LANE_DDR_NIB: begin
        nextRise = curByte[NIB_W-1:0];
        nextFall = curByte[NIB_W-1:0];
        shifted  = curByte >> NIB_W;
      end
      default: begin
        nextRise = {{(NIB_W-DIBIT_W){1'b0}}, curByte[DIBIT_W-1:0]};
        nextFall = {{(NIB_W-DIBIT_W){1'b0}}, curByte[DIBIT_W-1:0]};
        shifted  = curByte >> DIBIT_W;
      end
    endcase
    if (!curValid) begin
      nextRise = '0;
      nextFall = '0;
    end
  end

  // RMII has no error signalling on the transmit control pin
  assign nextFallC = (lane == LANE_SDR_DIBIT) ? curValid : (curValid & ~curErr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseD     <= '0;
      fallD     <= '0;
      riseC     <= 1'b0;
      fallC     <= 1'b0;
      holdByte  <= '0;
      holdValid <= 1'b0;
      holdErr   <= 1'b0;
    end else if (strobe.beat) begin
      riseD     <= nextRise;
      fallD     <= nextFall;
      riseC     <= curValid;
      fallC     <= nextFallC;
      holdByte  <= shifted;
      holdValid <= curValid & ~strobe.last;
      holdErr   <= curErr;
    end
  end

  AST_RMII_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN) modeRmii |-> (riseD[NIB_W-1:DIBIT_W] == '0 && fallD[NIB_W-1:DIBIT_W] == '0)); // R4
  AST_RMII_CTL_EQUAL: assert property (@(posedge clk) disable iff (!rstN) modeRmii |-> (riseC == fallC)); // R4
  AST_TX_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !riseC |-> (riseD == '0 && fallD == '0 && !fallC)); // R6
  AST_TX_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rstN) (slowRate && !strobe.beat) |=> $stable({riseD, fallD, riseC, fallC})); // R5

endmodule

// File: rtl/rgmiiRmiiRxPath.sv
module rgmiiRmiiRxPath
  import rgmiiRmiiPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeRmii,
  input  logic [1:0]        speedSel,
  input  beatStrobe_t       strobe,
  input  logic [NIB_W-1:0]  phyRxd,
  input  logic              phyRxCtl,
  output logic              sampleValid,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxError
);

  laneMode_e         lane;
  logic [NIB_W-1:0]  riseDq;
  logic              riseCq;
  logic [NIB_W-1:0]  fallDq;
  logic              fallCq;
  logic [BYTE_W-1:0] asmByte;
  logic [BYTE_W-1:0] nextAsm;
  logic              errAcc;
  logic              sampleErr;
  logic              errNext;

  assign lane = laneOf(modeRmii, speedSel);

  // Rising-edge capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseDq <= '0;
      riseCq <= 1'b0;
    end else begin
      riseDq <= phyRxd;
      riseCq <= phyRxCtl;
    end
  end

  // Falling-edge capture
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      fallDq <= '0;
      fallCq <= 1'b0;
    end else begin
      fallDq <= phyRxd;
      fallCq <= phyRxCtl;
    end
  end

  assign sampleValid = riseCq;
  assign sampleErr   = (lane == LANE_SDR_DIBIT) ? 1'b0 : (riseCq ^ fallCq);
  assign errNext     = (strobe.first ? 1'b0 : errAcc) | sampleErr;

  always_comb begin
    case (lane)
      LANE_DDR_BYTE: nextAsm = {fallDq, riseDq};
      LANE_DDR_NIB:  nextAsm = {riseDq, asmByte[BYTE_W-1:NIB_W]};
      default:       nextAsm = {riseDq[DIBIT_W-1:0], asmByte[BYTE_W-1:DIBIT_W]};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmByte <= '0;
      errAcc  <= 1'b0;
      rxData  <= '0;
      rxValid <= 1'b0;
      rxError <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strobe.beat) begin
        if (sampleValid) begin
          asmByte <= nextAsm;
          errAcc  <= errNext;
          if (strobe.last) begin
            rxData  <= nextAsm;
            rxValid <= 1'b1;
            rxError <= errNext;
          end
        end else begin
          errAcc <= 1'b0;
        end
      end
    end
  end

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN) (lane != LANE_DDR_BYTE && rxValid) |=> !rxValid); // R11
  AST_RMII_RX_NO_ERR: assert property (@(posedge clk) disable iff (!rstN) modeRmii |-> !rxError); // R9
  AST_RX_VALID_NEEDS_CTL: assert property (@(posedge clk) disable iff (!rstN) rxValid |-> $past(riseCq)); // R10

endmodule

// File: rtl/rgmiiRmiiAdapter.sv
module rgmiiRmiiAdapter
  import rgmiiRmiiPkg::*;
#(
  parameter int SLOW_DIV  = 10,
  parameter int MAX_BEATS = 4
) (
  input  logic              txClk,
  input  logic              rxClk,
  input  logic              rstN,
  input  logic              modeRmii,
  input  logic [1:0]        speedSel,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  input  logic              txError,
  output logic              txReady,
  output logic [NIB_W-1:0]  phyTxd,
  output logic              phyTxCtl,
  input  logic [NIB_W-1:0]  phyRxd,
  input  logic              phyRxCtl,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxError
);

  beatStrobe_t      txStb;
  beatStrobe_t      rxStb;
  logic             txAdvance;
  logic             rxSampleValid;
  logic [NIB_W-1:0] txRiseD;
  logic [NIB_W-1:0] txFallD;
  logic             txRiseC;
  logic             txFallC;

  // A byte in flight always finishes; a new one starts only if valid
  assign txAdvance = ~txStb.first | txValid;
  assign txReady   = txStb.beat & txStb.first;

  rgmiiRmiiBeatCtrl #(.SLOW_DIV(SLOW_DIV), .MAX_BEATS(MAX_BEATS)) txCtrl (
    .clk(txClk), .rstN(rstN), .modeRmii(modeRmii), .speedSel(speedSel),
    .advance(txAdvance), .strobe(txStb)
  );

  rgmiiRmiiTxPath txPath (
    .clk(txClk), .rstN(rstN), .modeRmii(modeRmii), .speedSel(speedSel),
    .strobe(txStb), .txData(txData), .txValid(txValid), .txError(txError),
    .riseD(txRiseD), .fallD(txFallD), .riseC(txRiseC), .fallC(txFallC)
  );

  // Behavioural DDR launch: high phase shows the rise register, low phase the fall register
  assign phyTxd   = txClk ? txRiseD : txFallD;
  assign phyTxCtl = txClk ? txRiseC : txFallC;

  rgmiiRmiiBeatCtrl #(.SLOW_DIV(SLOW_DIV), .MAX_BEATS(MAX_BEATS)) rxCtrl (
    .clk(rxClk), .rstN(rstN), .modeRmii(modeRmii), .speedSel(speedSel),
    .advance(rxSampleValid), .strobe(rxStb)
  );

  rgmiiRmiiRxPath rxPath (
    .clk(rxClk), .rstN(rstN), .modeRmii(modeRmii), .speedSel(speedSel),
    .strobe(rxStb), .phyRxd(phyRxd), .phyRxCtl(phyRxCtl),
    .sampleValid(rxSampleValid), .rxData(rxData), .rxValid(rxValid), .rxError(rxError)
  );

endmodule

// File: tb/rgmiiRmiiAdapter_test.sv
module rgmiiRmiiAdapter_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeRmii = 1'b0;
  logic [1:0] speedSel = 2'b10;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txError = 1'b0;
  logic       txReady;
  logic [3:0] phyTxd;
  logic       phyTxCtl;
  logic [3:0] phyRxd = '0;
  logic       phyRxCtl = 1'b0;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxError;

  int checks = 0;
  int errors = 0;
  logic [8:0] rxQ[$];
  logic [8:0] expQ[$];

  always #10 clk = ~clk;

  rgmiiRmiiAdapter uut (
    .txClk(clk), .rxClk(clk), .rstN(rstN), .modeRmii(modeRmii), .speedSel(speedSel),
    .txData(txData), .txValid(txValid), .txError(txError), .txReady(txReady),
    .phyTxd(phyTxd), .phyTxCtl(phyTxCtl), .phyRxd(phyRxd), .phyRxCtl(phyRxCtl),
    .rxData(rxData), .rxValid(rxValid), .rxError(rxError)
  );

  // Collect received bytes away from the active edge
  always @(negedge clk) begin
    if (rstN && rxValid) rxQ.push_back({rxError, rxData});
  end

  task automatic checkVal(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finishRun();
  end

  // R1: reset state, then release; returns at a quarter period before a rising edge
  task automatic applyReset(input logic rmii, input logic [1:0] spd);
    rstN = 1'b0;
    modeRmii = rmii;
    speedSel = spd;
    txValid = 1'b0; txData = '0; txError = 1'b0;
    phyRxd = '0; phyRxCtl = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    checkVal("R1", "phyTxd in reset", phyTxd, 0);
    checkVal("R1", "phyTxCtl in reset", phyTxCtl, 0);
    checkVal("R1", "rxValid in reset", rxValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    #5;
    rxQ.delete();
    expQ.delete();
  endtask

  task automatic txByte(input logic [7:0] b, input logic e, input string req);
    int beats;
    int hold;
    beats = modeRmii ? 4 : ((speedSel == 2'b10) ? 1 : 2);
    hold  = (modeRmii && speedSel == 2'b00) ? 10 : 1;
    txData = b; txValid = 1'b1; txError = e;
    while (txReady !== 1'b1) begin
      @(posedge clk);
      #15;
    end
    for (int k = 0; k < beats; k++) begin
      for (int h = 0; h < hold; h++) begin
        logic [3:0] expR;
        logic [3:0] expF;
        logic       expFc;
        if (modeRmii) begin
          expR = {2'b00, b[2*k +: 2]}; expF = expR; expFc = 1'b1;
        end else if (beats == 1) begin
          expR = b[3:0]; expF = b[7:4]; expFc = ~e;
        end else begin
          expR = b[4*k +: 4]; expF = expR; expFc = ~e;
        end
        @(posedge clk);
        #5;
        checkVal(req, "txd high phase", phyTxd, expR);
        checkVal(req, "ctl high phase", phyTxCtl, 1);
        #10;
        checkVal(req, "txd low phase", phyTxd, expF);
        checkVal(req, "ctl low phase", phyTxCtl, expFc);
        if (k < beats - 1 || h < hold - 1) checkVal(req, "txReady mid-byte", txReady, 0);
      end
    end
  endtask

  // R6: idle with junk on the data inputs
  task automatic txIdle();
    txValid = 1'b0; txError = 1'b1; txData = 8'hFF;
    while (txReady !== 1'b1) begin
      @(posedge clk);
      #15;
    end
    @(posedge clk);
    #5;
    checkVal("R6", "idle txd high", phyTxd, 0);
    checkVal("R6", "idle ctl high", phyTxCtl, 0);
    #10;
    checkVal("R6", "idle txd low", phyTxd, 0);
    checkVal("R6", "idle ctl low", phyTxCtl, 0);
  endtask

  task automatic rxCycle(input logic [3:0] rd, input logic rc, input logic [3:0] fd, input logic fc);
    @(negedge clk);
    #5;
    phyRxd = rd; phyRxCtl = rc;
    @(posedge clk);
    #5;
    phyRxd = fd; phyRxCtl = fc;
  endtask

  task automatic rxIdle(input int n);
    repeat (n) rxCycle(4'h0, 1'b0, 4'h0, 1'b0);
  endtask

  task automatic rxByte(input logic [7:0] b, input logic e);
    if (modeRmii) begin
      int hold;
      hold = (speedSel == 2'b00) ? 10 : 1;
      for (int k = 0; k < 4; k++)
        for (int h = 0; h < hold; h++)
          rxCycle({2'b11, b[2*k +: 2]}, 1'b1, {2'b11, b[2*k +: 2]}, 1'b1);
      expQ.push_back({1'b0, b});
    end else if (speedSel == 2'b10) begin
      rxCycle(b[3:0], 1'b1, b[7:4], ~e);
      expQ.push_back({e, b});
    end else begin
      rxCycle(b[3:0], 1'b1, b[3:0], ~e);
      rxCycle(b[7:4], 1'b1, b[7:4], ~e);
      expQ.push_back({e, b});
    end
  endtask

  // R10: send the first piece(s) of a byte with control high, then drop it
  task automatic rxPartial(input int pieces);
    for (int k = 0; k < pieces; k++)
      rxCycle(4'b1110, 1'b1, 4'b1110, 1'b1);
    rxIdle(1);
  endtask

  task automatic rxCompare(input string req);
    rxIdle(30);
    checkVal("R11", "received byte count", rxQ.size(), expQ.size());
    for (int i = 0; i < rxQ.size() && i < expQ.size(); i++)
      checkVal(req, "received {err,byte}", rxQ[i], expQ[i]);
    rxQ.delete();
    expQ.delete();
  endtask

  task automatic testRgmiiGig();
    applyReset(1'b0, 2'b10);
    txByte(8'h3C, 1'b0, "R2");
    txByte(8'hA7, 1'b1, "R2");
    txIdle();
    rxIdle(2);
    rxByte(8'h12, 1'b0);
    rxByte(8'hF0, 1'b1);
    rxByte(8'h5D, 1'b0);
    rxCompare("R7");
  endtask

  task automatic testRgmiiNibble(input logic [1:0] spd);
    applyReset(1'b0, spd);
    txByte(8'h5A, 1'b0, "R3");
    txByte(8'hC3, 1'b1, "R3");
    txIdle();
    rxIdle(2);
    rxByte(8'h6B, 1'b0);
    rxByte(8'h81, 1'b1);
    rxCompare("R8");
    rxPartial(1);
    rxByte(8'h4D, 1'b0);
    rxCompare("R10");
  endtask

  task automatic testRmiiFast();
    applyReset(1'b1, 2'b01);
    txByte(8'hB4, 1'b1, "R4");
    txByte(8'h1E, 1'b0, "R4");
    txIdle();
    rxIdle(2);
    rxByte(8'h9C, 1'b0);
    rxByte(8'h27, 1'b0);
    rxCompare("R9");
    rxPartial(2);
    rxByte(8'h71, 1'b0);
    rxCompare("R10");
  endtask

  task automatic testRmiiSlow();
    applyReset(1'b1, 2'b00);
    txByte(8'hD2, 1'b0, "R5");
    txByte(8'h69, 1'b1, "R5");
    txIdle();
    rxIdle(20);
    rxByte(8'h5E, 1'b0);
    rxByte(8'hA3, 1'b0);
    rxCompare("R9");
  endtask

  initial begin
    testRgmiiGig();
    testRgmiiNibble(2'b01);
    testRgmiiNibble(2'b00);
    testRmiiFast();
    testRmiiSlow();
    finishRun();
  end

endmodule